// File: doc/BRIEF.md
# Dual-Mode Multi-Cycle Multiply Unit

This block is a multiply execution unit whose value lies in its timing rather than its arithmetic. An issue carries two unsigned operands, a destination register index, a precision select and a per-operation suppress flag. The product is a plain unsigned integer product, with no rounding and no exception handling. It lands in a small internal register file after a latency that depends on the precision. Single precision runs through three one-cycle stages, for a latency of 3 clocks. Double precision runs through two two-cycle stages, for a latency of 4 clocks.

A mode input selects how operations overlap. In pipelined mode a new operation may enter on every clock, in either precision, and one result retires per clock once the pipe is full. For double precision this works because each two-cycle stage is duplicated, so the pipe holds four slots. In non-pipelined mode one operation is in flight at a time. A down-counter meters the cycles left before writeback, and the destination index is captured at issue. While operations are in flight, an issue whose mode or precision differs from theirs is refused. A register-file read port lets the surroundings observe the results.

The controller is a three-state machine:
- ST_IDLE: nothing is in flight.
- ST_PIPE: at least one pipelined operation is in flight.
- ST_SEQ: a single non-pipelined operation is counting down.

Its transitions are:
- IDLE→PIPE: an accepted issue with pipelined mode.
- IDLE→SEQ: an accepted issue with non-pipelined mode.
- PIPE→PIPE: a new accept, or operations still ahead of writeback.
- PIPE→IDLE: the last operation retires and nothing new is accepted.
- SEQ→SEQ: the counter is not yet zero.
- SEQ→IDLE: writeback, when the counter reads zero.

Top module: `mpy_lat_unit`

## Requirements
- R1: After reset every register-file entry reads 0, `busy` is 0 and `issue_ready` is 1.
- R2: In pipelined mode (`mode_pipe`=1) with single precision (`prec_dbl`=0), an operation accepted at clock edge E becomes readable after edge E+3, and is not yet readable after edge E+2.
- R3: In pipelined mode with double precision (`prec_dbl`=1), an operation accepted at edge E becomes readable after edge E+4, and is not yet readable after edge E+3.
- R4: In pipelined mode `issue_ready` stays 1 for back-to-back issues of one precision. Consecutive operations retire on consecutive clocks, each at its own precision's latency.
- R5: In non-pipelined mode (`mode_pipe`=0), the unit works as follows. `busy` is 1 from the accepting edge until the writeback edge, which comes 3 edges later (single) or 4 edges later (double). `issue_ready` is 0 while `busy` is 1, and the result is not readable before the writeback edge.
- R6: In non-pipelined mode the destination index is captured at issue. Changing `dst_idx` afterwards does not redirect the result.
- R7: An operation issued with `issue_nowb`=1 never writes the register file, so its destination keeps its earlier value. Operations in flight around it still write.
- R8: While operations are in flight, an issue whose `mode_pipe` or `prec_dbl` differs from theirs sees `issue_ready`=0. It is not performed, so its destination is unchanged.
- R9: The value written is the unsigned product of the two 16-bit operands, as a 32-bit result (0xFFFF × 0xFFFF = 0xFFFE0001).
- R10: An issue presented while a non-pipelined operation is busy is not accepted, so its destination is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_pipe | input | 1 | 1 = pipelined, 0 = non-pipelined |
| prec_dbl | input | 1 | 1 = double precision, 0 = single |
| issue_valid | input | 1 | Issue request |
| issue_ready | output | 1 | Issue is accepted on an edge where valid and ready are both 1 |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second operand |
| dst_idx | input | 3 | Destination register index |
| issue_nowb | input | 1 | 1 = suppress writeback of this operation |
| busy | output | 1 | Non-pipelined operation in flight |
| rd_idx | input | 3 | Register-file read index |
| rd_data | output | 32 | Register-file read data (combinational) |

## Verification
The hardest situation to reach is a burst in which a suppressed operation sits between operations that must still write. It has to be placed against a destination that already holds a known non-zero value, so that a stray write would show. The bench first loads that register through an ordinary issue. It then drives four issues on consecutive clocks from a single task and samples the register file both at the moment the first result lands and after the pipe drains. A second hard case is the refused reconfiguration: the bench changes precision, then mode, on the very cycles that follow an accepted issue, while the pipe is still full.

// File: rtl/mpy_lat_pkg.sv
package mpy_lat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PIPE = 2'd1,
        ST_SEQ  = 2'd2
    } mpy_state_e;

    function automatic int lat_of(input int stages, input int cyc);
        return stages * cyc;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mpy_delay_line.sv
module mpy_delay_line #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic [W-1:0]              in_dat,
    output logic [DEPTH-1:0]          vld,
    output logic [DEPTH-1:0][W-1:0]   dat
);

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        if (k == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld[k] <= 1'b0;
                    dat[k] <= '0;
                end else begin
                    vld[k] <= in_vld;
                    dat[k] <= in_dat;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld[k] <= 1'b0;
                    dat[k] <= '0;
                end else begin
                    vld[k] <= vld[k-1];
                    dat[k] <= dat[k-1];
                end
            end

            AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
                vld[k-1] |=> vld[k]);  // R4
        end
    end

endmodule

// File: rtl/mpy_regfile.sv
module mpy_regfile #(
    parameter int NREG = 8,
    parameter int W    = 32,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);

    logic [NREG-1:0][W-1:0] cells;

    for (genvar r = 0; r < NREG; r++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[r] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(r))) begin
                cells[r] <= wr_data;
            end
        end
    end

    assign rd_data = cells[rd_idx];

endmodule

// File: rtl/mpy_lat_unit.sv
module mpy_lat_unit
    import mpy_lat_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NREG      = 8,
    parameter int SP_STAGES = 3,
    parameter int SP_CYC    = 1,
    parameter int DP_STAGES = 2,
    parameter int DP_CYC    = 2,
    localparam int IDX_W    = $clog2(NREG),
    localparam int RES_W    = 2 * DATA_W,
    localparam int SP_LAT   = lat_of(SP_STAGES, SP_CYC),
    localparam int DP_LAT   = lat_of(DP_STAGES, DP_CYC),
    localparam int MAX_LAT  = max_of(SP_LAT, DP_LAT),
    localparam int TAP_W    = max_of($clog2(MAX_LAT), 1),
    localparam int PL_W     = 1 + IDX_W + RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_pipe,
    input  logic              prec_dbl,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IDX_W-1:0]  dst_idx,
    input  logic              issue_nowb,
    output logic              busy,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [RES_W-1:0]  rd_data
);

    mpy_state_e state, state_nx;

    logic                          accept;
    logic                          cfg_dbl;
    logic [RES_W-1:0]              prod_in;
    logic [PL_W-1:0]               pl_in;
    logic [TAP_W-1:0]              last_slot;
    logic [TAP_W-1:0]              issue_last;
    logic [MAX_LAT-1:0]            dl_vld;
    logic [MAX_LAT-1:0][PL_W-1:0]  dl_dat;
    logic [PL_W-1:0]               tap_pl;
    logic                          pend;
    logic [TAP_W-1:0]              seq_cnt;
    logic [PL_W-1:0]               seq_pl;
    logic                          pipe_wr;
    logic                          seq_wr;
    logic                          rf_we;
    logic [IDX_W-1:0]              rf_widx;
    logic [RES_W-1:0]              rf_wdat;

    // operand product and issue payload {nowb, idx, product}
    assign prod_in = RES_W'(src_a) * RES_W'(src_b);
    assign pl_in   = {issue_nowb, dst_idx, prod_in};
    assign accept  = issue_valid && issue_ready;

    assign last_slot  = cfg_dbl  ? TAP_W'(DP_LAT - 1) : TAP_W'(SP_LAT - 1);
    assign issue_last = prec_dbl ? TAP_W'(DP_LAT - 1) : TAP_W'(SP_LAT - 1);

    mpy_delay_line #(
        .DEPTH (MAX_LAT),
        .W     (PL_W)
    ) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (accept && mode_pipe),
        .in_dat (pl_in),
        .vld    (dl_vld),
        .dat    (dl_dat)
    );

    assign tap_pl = dl_dat[last_slot];

    // operations still ahead of the writeback slot
    always_comb begin
        pend = 1'b0;
        for (int k = 0; k < MAX_LAT; k++) begin
            if ((k < int'(last_slot)) && dl_vld[k]) begin
                pend = 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = mode_pipe ? ST_PIPE : ST_SEQ;
            ST_PIPE: state_nx = (accept || pend) ? ST_PIPE : ST_IDLE;
            ST_SEQ:  state_nx = (seq_cnt == '0) ? ST_IDLE : ST_SEQ;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        issue_ready = 1'b0;
        busy        = 1'b0;
        unique case (state)
            ST_IDLE: issue_ready = 1'b1;
            ST_PIPE: issue_ready = mode_pipe && (prec_dbl == cfg_dbl);
            ST_SEQ:  busy = 1'b1;
            default: issue_ready = 1'b0;
        endcase
    end

    // in-flight configuration and non-pipelined countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_dbl <= 1'b0;
            seq_cnt <= '0;
            seq_pl  <= '0;
        end else begin
            if (accept && (state == ST_IDLE)) cfg_dbl <= prec_dbl;
            if (accept && !mode_pipe) begin
                seq_cnt <= issue_last;
                seq_pl  <= pl_in;
            end else if ((state == ST_SEQ) && (seq_cnt != '0)) begin
                seq_cnt <= seq_cnt - 1'b1;
            end
        end
    end

    // writeback selection
    assign pipe_wr = (state == ST_PIPE) && dl_vld[last_slot] && !tap_pl[PL_W-1];
    assign seq_wr  = (state == ST_SEQ) && (seq_cnt == '0) && !seq_pl[PL_W-1];
    assign rf_we   = pipe_wr || seq_wr;
    assign rf_widx = seq_wr ? seq_pl[RES_W +: IDX_W] : tap_pl[RES_W +: IDX_W];
    assign rf_wdat = seq_wr ? seq_pl[RES_W-1:0]      : tap_pl[RES_W-1:0];

    mpy_regfile #(
        .NREG (NREG),
        .W    (RES_W)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rf_we),
        .wr_idx  (rf_widx),
        .wr_data (rf_wdat),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    AST_SEQ_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEQ) |-> !issue_ready);  // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEQ) && (seq_cnt != '0)) |=> (seq_cnt == $past(seq_cnt) - 1'b1));  // R5

    AST_SEQ_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SEQ) && (seq_cnt == '0)) |=> (state == ST_IDLE));  // R5

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pipe_wr, seq_wr}));  // R5

    AST_CFG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (state != ST_IDLE)) |-> (mode_pipe && (prec_dbl == cfg_dbl)));  // R8

endmodule

// File: tb/mpy_lat_unit_tb_top.sv
module mpy_lat_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_pipe = 1'b1;
    logic        prec_dbl = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic [2:0]  dst_idx = '0;
    logic        issue_nowb = 1'b0;
    logic        busy;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    mpy_lat_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_pipe   (mode_pipe),
        .prec_dbl    (prec_dbl),
        .issue_valid (issue_valid),
        .issue_ready (issue_ready),
        .src_a       (src_a),
        .src_b       (src_b),
        .dst_idx     (dst_idx),
        .issue_nowb  (issue_nowb),
        .busy        (busy),
        .rd_idx      (rd_idx),
        .rd_data     (rd_data)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int idx, input logic [31:0] exp);
        rd_idx = 3'(idx);
        #1;
        chk(req, $sformatf("reg%0d", idx), rd_data, exp);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input int dst, input bit nowb);
        src_a = a; src_b = b; dst_idx = 3'(dst); issue_nowb = nowb; issue_valid = 1'b1;
    endtask

    // single issue; returns at the negedge after the accepting edge
    task automatic issue1(input logic [15:0] a, input logic [15:0] b, input int dst, input bit nowb,
                          output logic took);
        @(negedge clk);
        drive(a, b, dst, nowb);
        #1 took = issue_ready;
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "issue_ready", 32'(issue_ready), 32'd1);
        for (int i = 0; i < 8; i++) chk_reg("R1", i, 32'd0);
    endtask

    task automatic t_single_pipe;
        logic took;
        mode_pipe = 1'b1; prec_dbl = 1'b0;
        issue1(16'd3, 16'd5, 1, 1'b0, took);
        chk("R4", "ready on idle issue", 32'(took), 32'd1);
        wait_edges(2);
        chk_reg("R2", 1, 32'd0);           // not yet after E+2
        wait_edges(1);
        chk_reg("R2", 1, 32'd15);          // landed after E+3
    endtask

    task automatic t_double_pipe;
        logic took;
        mode_pipe = 1'b1; prec_dbl = 1'b1;
        issue1(16'd7, 16'd9, 2, 1'b0, took);
        wait_edges(3);
        chk_reg("R3", 2, 32'd0);
        wait_edges(1);
        chk_reg("R3", 2, 32'd63);
    endtask

    task automatic t_burst_single;
        logic took;
        logic [15:0] a_v [4] = '{16'd2, 16'd4, 16'd6, 16'd8};
        logic [15:0] b_v [4] = '{16'd3, 16'd5, 16'd7, 16'd9};
        int          d_v [4] = '{4, 3, 5, 6};
        bit          n_v [4] = '{1'b0, 1'b1, 1'b0, 1'b0};
        mode_pipe = 1'b1; prec_dbl = 1'b0;
        issue1(16'd5, 16'd17, 3, 1'b0, took);   // preload reg3 = 85
        wait_edges(3);
        chk_reg("R7", 3, 32'd85);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            drive(a_v[i], b_v[i], d_v[i], n_v[i]);
            #1 chk("R4", $sformatf("ready burst op%0d", i), 32'(issue_ready), 32'd1);
            @(posedge clk);
        end
        @(negedge clk);
        issue_valid = 1'b0;
        issue_nowb  = 1'b0;
        chk_reg("R4", 4, 32'd6);            // op0 retired after E+3
        chk_reg("R4", 5, 32'd0);            // op2 not yet
        wait_edges(4);
        chk_reg("r7_", 3, 32'd85);          // suppressed op left reg3 alone
        chk_reg("R7", 5, 32'd42);
        chk_reg("R7", 6, 32'd72);
    endtask

    task automatic t_burst_double;
        mode_pipe = 1'b1; prec_dbl = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            drive(16'(10 + i), 16'(10 + i), (i == 2) ? 7 : i, 1'b0);
            #1 chk("R4", $sformatf("ready double burst op%0d", i), 32'(issue_ready), 32'd1);
            @(posedge clk);
        end
        @(negedge clk);
        issue_valid = 1'b0;
        wait_edges(1);                      // after E+3
        chk_reg("R3", 0, 32'd0);
        wait_edges(1);                      // after E+4
        chk_reg("R3", 0, 32'd100);
        chk_reg("R4", 1, 32'd15);
        wait_edges(1);
        chk_reg("R4", 1, 32'd121);
        wait_edges(1);
        chk_reg("R4", 7, 32'd144);
    endtask

    task automatic t_reject;
        logic took;
        mode_pipe = 1'b1; prec_dbl = 1'b0;
        @(negedge clk);
        drive(16'd1, 16'd2, 0, 1'b0);
        #1 took = issue_ready;
        chk("R8", "first op accepted", 32'(took), 32'd1);
        @(posedge clk);
        @(negedge clk);
        prec_dbl = 1'b1;
        drive(16'd9, 16'd9, 1, 1'b0);
        #1 chk("R8", "ready with precision change", 32'(issue_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        prec_dbl = 1'b0; mode_pipe = 1'b0;
        #1 chk("R8", "ready with mode change", 32'(issue_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        issue_valid = 1'b0; mode_pipe = 1'b1;
        wait_edges(4);
        chk_reg("R8", 1, 32'd121);
        chk_reg("R8", 0, 32'd2);
    endtask

    task automatic t_np_single;
        logic took;
        mode_pipe = 1'b0; prec_dbl = 1'b0;
        issue1(16'd13, 16'd3, 4, 1'b0, took);
        chk("R5", "np accepted", 32'(took), 32'd1);
        chk("R5", "busy after issue", 32'(busy), 32'd1);
        chk("R5", "ready low while busy", 32'(issue_ready), 32'd0);
        drive(16'd2, 16'd2, 6, 1'b0);      // new dst and an issue while busy
        wait_edges(1);
        chk("R10", "busy held", 32'(busy), 32'd1);
        wait_edges(1);
        chk("R5", "busy at E+2", 32'(busy), 32'd1);
        chk_reg("R5", 4, 32'd6);
        issue_valid = 1'b0;
        wait_edges(1);
        chk("R5", "busy after writeback", 32'(busy), 32'd0);
        chk_reg("R6", 4, 32'd39);
        chk_reg("R10", 6, 32'd72);
    endtask

    task automatic t_np_double;
        logic took;
        mode_pipe = 1'b0; prec_dbl = 1'b1;
        issue1(16'hFFFF, 16'hFFFF, 5, 1'b0, took);
        wait_edges(3);
        chk("R5", "double busy at E+3", 32'(busy), 32'd1);
        chk_reg("R5", 5, 32'd42);
        wait_edges(1);
        chk("R5", "double busy released", 32'(busy), 32'd0);
        chk_reg("R9", 5, 32'hFFFE0001);
    endtask

    task automatic t_np_suppress;
        logic took;
        mode_pipe = 1'b0; prec_dbl = 1'b0;
        issue1(16'd3, 16'd3, 4, 1'b1, took);
        wait_edges(3);
        chk("R7", "np suppressed retires", 32'(busy), 32'd0);
        chk_reg("R7", 4, 32'd39);
        issue_nowb = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_pipe();
        t_double_pipe();
        t_burst_single();
        t_burst_double();
        t_reject();
        t_np_single();
        t_np_double();
        t_np_suppress();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule